// File: doc/BRIEF.md
# Audio Frame Sequencer with IRQ

This block paces the slow control units of an audio processing unit. It advances once per CPU cycle and issues two strobes. The quarter strobe drives the envelope units. The half strobe drives the sweep and length units. It runs either a four-step schedule or a five-step schedule. A static input selects between two timing tables, one for 60 Hz systems and one for 50 Hz systems.

Software programs the sequencer through an 8-bit control write. The write waits 3 or 4 cycles before it takes effect, and the CPU side selects which of the two delays applies. When the write lands, the counter restarts from zero. Writes that select the five-step schedule also produce an immediate quarter strobe and half strobe. In the four-step schedule, unless inhibited, the block raises a sticky frame interrupt flag near the end of every sequence. A clear input resets that flag. The current count is brought out for observation.

Top module: `afs_frame_seq`

## Requirements
- R1: After synchronous reset the block is in four-step mode with inhibit clear. The count reads 0, both strobes and the interrupt flag are low, no write is pending, and the five-step offset is zero.
- R2: Four-step, 60 Hz table. `qtr_o` pulses on the edges where `cnt_o` becomes 7457, 14913, 22371 and 29829. `half_o` pulses only at 14913 and 29829. On the edge after 29829 the count becomes 0.
- R3: Five-step, 60 Hz table, zero offset. Quarter strobes fire at 7457, 14913, 22371 and 37281. Half strobes fire at 14913 and 37281. Count 29829 gives no strobe. The count returns to 0 on the same edge that it reaches the last step, so `cnt_o` reads 0 while that strobe is shown.
- R4: In five-step mode every step moves one count later on alternate sequences. The offset flips at each five-step wrap, and any write that takes effect clears it. The second sequence after a write therefore has its first quarter strobe at 7458, not 7457.
- R5: With `pal_sel`=1 the four-step steps are 8313, 16627 (with half), 24939 and 33253 (with half). The interrupt is at 33252 and the count becomes 0 on the edge after 33253. The five-step steps are 8313, 16627, 24939 and 41565.
- R6: Control byte decode. Bit 7 = 1 selects five-step and bit 7 = 0 selects four-step. Bit 6 = 1 inhibits the interrupt. Bits 5:0 have no effect.
- R7: A write is sampled on an edge with `wr_en`=1. It takes effect 3 edges later (`wr_long`=0) or 4 edges later (`wr_long`=1). On that edge `cnt_o` becomes 0 and is not also incremented, so it reads 1 one edge later. A new write replaces a pending one.
- R8: A write that takes effect with bit 7 = 1 raises `qtr_o` and `half_o` on the edge it takes effect, unless R12 suppresses them. A write with bit 7 = 0 raises neither.
- R9: In four-step mode with inhibit clear, `irq_o` is set on the three edges where the count becomes 29828, 29829 and 0 (the wrap). A clear on any of those edges is overridden. Five-step mode never sets the flag.
- R10: `irq_o` stays high until the edge after `irq_clr`=1 (outside the R9 window), or until a write with bit 6 = 1 takes effect. A write with bit 6 = 0 leaves the flag unchanged.
- R11: While inhibit is set, `irq_o` never rises.
- R12: On the edge right after any edge that showed a strobe, both strobes are forced low. This includes the immediate strobes of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| pal_sel | input | 1 | Static table select: 0 = 60 Hz table, 1 = 50 Hz table |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Control byte (bit 7 mode, bit 6 inhibit) |
| wr_long | input | 1 | Delay select for this write: 0 = 3 cycles, 1 = 4 cycles |
| irq_clr | input | 1 | Clears the interrupt flag |
| qtr_o | output | 1 | Quarter-frame strobe |
| half_o | output | 1 | Half-frame strobe |
| irq_o | output | 1 | Frame interrupt flag |
| cnt_o | output | 16 | Current cycle count |

## Verification
All outputs are registered. A strobe or flag change is seen on the same edge that the count takes its new value, and the bench ties each expected strobe to the `cnt_o` value shown alongside it. Writes land 3 or 4 edges after the edge that samples `wr_en`, and clears act on the next edge. The bench drives stimulus at falling edges and counts the edges between stimulus and check, so each check samples exactly the edge where the result is due. A scoreboard queue holds every expected strobe together with its count. A falling-edge monitor pops one entry for each strobe it sees, and it reports any strobe that arrives when nothing is expected.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int MODE_BIT = 7;
    localparam int INH_BIT  = 6;
    localparam int WIN_CYC  = 3;
    localparam int WIN_W    = $clog2(WIN_CYC + 1);
    localparam int DLY_SHORT = 3;
    localparam int DLY_LONG  = 4;
    localparam int DLY_W     = $clog2(DLY_LONG + 1);

    typedef struct packed {
        logic [CNT_W-1:0] s1;
        logic [CNT_W-1:0] s2;
        logic [CNT_W-1:0] s3;
        logic [CNT_W-1:0] s4;
        logic [CNT_W-1:0] irq_at;
        logic [CNT_W-1:0] len4;
        logic [CNT_W-1:0] s5;
    } afs_tab_t;

    localparam afs_tab_t TAB_60 = '{s1: 16'd7457, s2: 16'd14913, s3: 16'd22371,
                                   s4: 16'd29829, irq_at: 16'd29828,
                                   len4: 16'd29830, s5: 16'd37281};
    localparam afs_tab_t TAB_50 = '{s1: 16'd8313, s2: 16'd16627, s3: 16'd24939,
                                   s4: 16'd33253, irq_at: 16'd33252,
                                   len4: 16'd33254, s5: 16'd41565};
endpackage

// File: rtl/afs_wr_pipe.sv
module afs_wr_pipe
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_long,
    output logic              apply,
    output logic [BYTE_W-1:0] apply_data
);
    typedef struct packed {
        logic              pend;
        logic [DLY_W-1:0]  dly;
        logic [BYTE_W-1:0] data;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d   = p_q;
        apply = 1'b0;
        if (wr_en) begin
            p_d.pend = 1'b1;
            p_d.data = wr_data;
            p_d.dly  = wr_long ? DLY_W'(DLY_LONG) : DLY_W'(DLY_SHORT);
        end else if (p_q.pend) begin
            if (p_q.dly <= DLY_W'(1)) begin
                apply    = 1'b1;
                p_d.pend = 1'b0;
            end else begin
                p_d.dly = p_q.dly - 1'b1;
            end
        end
    end

    assign apply_data = p_q.data;

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end
endmodule

// File: rtl/afs_step_dec.sv
module afs_step_dec
    import afs_pkg::*;
(
    input  afs_tab_t         tab,
    input  logic             five,
    input  logic             odd,
    input  logic [CNT_W-1:0] cnt,
    output logic             qtr,
    output logic             half,
    output logic             irq_hit,
    output logic             wrap
);
    logic [CNT_W-1:0] off, p1, p2, p3, p5;

    always_comb begin
        off = {{(CNT_W-1){1'b0}}, odd};
        p1  = tab.s1 + off;
        p2  = tab.s2 + off;
        p3  = tab.s3 + off;
        p5  = tab.s5 + off;
        if (five) begin
            qtr     = (cnt == p1) || (cnt == p2) || (cnt == p3) || (cnt == p5);
            half    = (cnt == p2) || (cnt == p5);
            irq_hit = 1'b0;
            wrap    = (cnt >= p5);
        end else begin
            qtr     = (cnt == tab.s1) || (cnt == tab.s2) || (cnt == tab.s3) || (cnt == tab.s4);
            half    = (cnt == tab.s2) || (cnt == tab.s4);
            irq_hit = (cnt == tab.irq_at);
            wrap    = (cnt >= tab.len4);
        end
    end
endmodule

// File: rtl/afs_frame_seq.sv
module afs_frame_seq
    import afs_pkg::*;
#(
    parameter afs_tab_t NTSC_TAB = TAB_60,
    parameter afs_tab_t PAL_TAB  = TAB_50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pal_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_long,
    input  logic              irq_clr,
    output logic              qtr_o,
    output logic              half_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic             five;
        logic             inh;
        logic             odd;
        logic             irq;
        logic             blk;
        logic             qtr;
        logic             half;
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    logic              wr_apply;
    logic [BYTE_W-1:0] wr_val;
    afs_tab_t          tab;

    logic             five_pre, inh_pre, odd_pre, irq_pre, imm_pre;
    logic [WIN_W-1:0] win_pre;
    logic [CNT_W-1:0] cnt_pre;
    logic             dq, dh, dirq, dwrap;

    afs_wr_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_long    (wr_long),
        .apply      (wr_apply),
        .apply_data (wr_val)
    );

    assign tab = pal_sel ? PAL_TAB : NTSC_TAB;

    // Stage 1: clear, write landing, count advance
    always_comb begin
        five_pre = s_q.five;
        inh_pre  = s_q.inh;
        odd_pre  = s_q.odd;
        win_pre  = s_q.win;
        irq_pre  = s_q.irq && !irq_clr;
        imm_pre  = 1'b0;
        cnt_pre  = s_q.cnt + 1'b1;
        if (wr_apply) begin
            five_pre = wr_val[MODE_BIT];
            inh_pre  = wr_val[INH_BIT];
            odd_pre  = 1'b0;
            win_pre  = '0;
            cnt_pre  = '0;
            imm_pre  = wr_val[MODE_BIT];
            if (wr_val[INH_BIT]) irq_pre = 1'b0;
        end
    end

    afs_step_dec u_dec (
        .tab     (tab),
        .five    (five_pre),
        .odd     (odd_pre),
        .cnt     (cnt_pre),
        .qtr     (dq),
        .half    (dh),
        .irq_hit (dirq),
        .wrap    (dwrap)
    );

    // Stage 2: window, wrap, strobes, suppression
    always_comb begin
        logic [WIN_W-1:0] win_cur;
        logic             q_raw, h_raw;
        s_d      = s_q;
        s_d.five = five_pre;
        s_d.inh  = inh_pre;
        s_d.odd  = odd_pre;
        s_d.irq  = irq_pre;
        s_d.win  = win_pre;
        s_d.cnt  = cnt_pre;
        win_cur  = (dirq && !inh_pre) ? WIN_W'(WIN_CYC) : win_pre;
        if (!five_pre && (win_cur != '0)) begin
            if (!inh_pre) s_d.irq = 1'b1;
            s_d.win = win_cur - 1'b1;
        end
        if (dwrap) begin
            s_d.cnt = '0;
            if (five_pre) s_d.odd = !odd_pre;
        end
        q_raw    = dq || imm_pre;
        h_raw    = dh || imm_pre;
        s_d.qtr  = q_raw && !s_q.blk;
        s_d.half = h_raw && !s_q.blk;
        s_d.blk  = s_d.qtr || s_d.half;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign qtr_o  = s_q.qtr;
    assign half_o = s_q.half;
    assign irq_o  = s_q.irq;
    assign cnt_o  = s_q.cnt;
endmodule

// File: rtl/afs_frame_seq_chk.sv
module afs_frame_seq_chk
    import afs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             qtr,
    input logic             half,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             five,
    input logic             inh,
    input logic             apply,
    input logic [CNT_W-1:0] irq_at
);
    // R12: no strobe on the edge after a strobe
    p_strobe_gap_r12: assert property (@(posedge clk) disable iff (rst)
        (qtr || half) |=> !(qtr || half));

    // R2/R3: a half strobe always comes with a quarter strobe
    p_half_with_qtr_r2: assert property (@(posedge clk) disable iff (rst)
        half |-> qtr);

    // R9: flag only rises at the interrupt count
    p_irq_rise_cnt_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt == irq_at));

    // R9: five-step mode never raises the flag
    p_no_irq_five_r9: assert property (@(posedge clk) disable iff (rst)
        five |-> !$rose(irq));

    // R11: inhibit blocks the flag
    p_no_irq_inh_r11: assert property (@(posedge clk) disable iff (rst)
        inh |-> !$rose(irq));

    // R7: landing write restarts the count at zero
    p_apply_zero_r7: assert property (@(posedge clk) disable iff (rst)
        apply |=> (cnt == '0));
endmodule

bind afs_frame_seq afs_frame_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .qtr    (qtr_o),
    .half   (half_o),
    .irq    (irq_o),
    .cnt    (cnt_o),
    .five   (s_q.five),
    .inh    (s_q.inh),
    .apply  (wr_apply),
    .irq_at (tab.irq_at)
);

// File: tb/afs_frame_seq_bench.sv
module afs_frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pal_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_long = 1'b0;
    logic        irq_clr = 1'b0;
    logic        qtr_o, half_o, irq_o;
    logic [15:0] cnt_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [17:0] exp_q[$];

    always #5 clk = ~clk;

    afs_frame_seq u_afs_frame_seq (
        .clk(clk), .rst(rst), .pal_sel(pal_sel), .wr_en(wr_en),
        .wr_data(wr_data), .wr_long(wr_long), .irq_clr(irq_clr),
        .qtr_o(qtr_o), .half_o(half_o), .irq_o(irq_o), .cnt_o(cnt_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int c, input bit q, input bit h);
        exp_q.push_back({c[15:0], q, h});
    endtask

    task automatic wait_cnt(input int v);
        while (cnt_o !== v[15:0]) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d, input bit long_dly);
        wr_en = 1'b1; wr_data = d; wr_long = long_dly;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Scoreboard monitor: every strobe must match the next expected entry
    always @(negedge clk) begin
        if (!rst && !done && (qtr_o || half_o)) begin
            if (exp_q.size() == 0) begin
                total++; fails++;
                $display("FAIL R2/R3/R12 unexpected strobe: actual cnt %0d q %0d h %0d expected none",
                         cnt_o, qtr_o, half_o);
            end else begin
                check("strobe schedule R2 R3 R4 R5 R8", {14'd0, cnt_o, qtr_o, half_o},
                      {14'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        step(5);
        check("R1 count", cnt_o, 0);
        check("R1 strobes", {qtr_o, half_o}, 0);
        check("R1 irq", irq_o, 0);
        rst = 1'b0;

        // Four-step write, long delay, counter restart (R7, R8)
        wait_cnt(200);
        write(8'h00, 1'b1);
        step(3);
        check("R7 before landing", cnt_o, 204);
        step(1);
        check("R7 landing zero", cnt_o, 0);
        check("R8 no immediate", {qtr_o, half_o}, 0);
        step(1);
        check("R7 no increment on landing", cnt_o, 1);
        push(7457, 1, 0); push(14913, 1, 1); push(22371, 1, 0); push(29829, 1, 1);

        // IRQ window and clear override (R9, R10)
        wait_cnt(29828);
        check("R9 irq set at window start", irq_o, 1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        check("R9 clear in window overridden", irq_o, 1);
        step(1);
        check("R2 wrap to zero", cnt_o, 0);
        check("R9 irq at wrap", irq_o, 1);
        wait_cnt(100);
        check("R10 irq sticky", irq_o, 1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        check("R10 irq cleared", irq_o, 0);

        // Second frame; five-step write landing right after step 4 (R12)
        push(7457, 1, 0); push(14913, 1, 1); push(22371, 1, 0); push(29829, 1, 1);
        wait_cnt(29826);
        write(8'h80, 1'b0);
        step(1);
        check("R9 irq set again", irq_o, 1);
        step(2);
        check("R7 short delay landing", cnt_o, 0);
        check("R12 immediate strobe suppressed", {qtr_o, half_o}, 0);
        check("R10 bit6 zero keeps flag", irq_o, 1);

        // Inhibit write clears flag and gives immediate strobes (R6, R8, R10)
        wait_cnt(100);
        push(0, 1, 1);
        write(8'hC0, 1'b0);
        step(3);
        check("R10 inhibit write clears flag", irq_o, 0);
        check("R8 immediate strobes", {qtr_o, half_o}, 2'b11);

        // Five-step full sequence and offset (R3, R4, R6)
        wait_cnt(100);
        push(0, 1, 1);
        push(7457, 1, 0); push(14913, 1, 1); push(22371, 1, 0); push(0, 1, 1);
        push(7458, 1, 0);
        write(8'hBF, 1'b0);
        step(3);
        check("R6 low bits ignored, five-step", cnt_o, 0);
        wait_cnt(29829);
        check("R3 no strobe at 29829", {qtr_o, half_o}, 0);
        check("R9 five-step no irq", irq_o, 0);
        wait_cnt(37280);
        step(1);
        check("R3 wrap on last step", cnt_o, 0);
        check("R3 last step strobes", {qtr_o, half_o}, 2'b11);
        wait_cnt(7457);
        check("R4 shifted step not at 7457", qtr_o, 0);
        step(1);
        check("R4 shifted step at 7458", qtr_o, 1);

        // 50 Hz four-step with inhibit (R5, R6, R11)
        wait_cnt(7460);
        pal_sel = 1'b1;
        push(8313, 1, 0); push(16627, 1, 1); push(24939, 1, 0); push(33253, 1, 1);
        write(8'h7F, 1'b0);
        step(3);
        check("R6 four-step selected, no immediate", {qtr_o, half_o}, 0);
        check("R7 landing zero", cnt_o, 0);
        wait_cnt(33252);
        step(2);
        check("R11 inhibited irq", irq_o, 0);
        check("R5 wrap to zero", cnt_o, 0);

        check("R2 R3 R5 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule